// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Acknowledge and Vector Unit

This block joins two eight-input interrupt slices into a two-level tree. The lower slice (the slave) resolves its own requests, and whenever it has one worth signalling, it raises a request on line 2 of the upper slice (the master). The master's resolved request drives the processor interrupt output. When the processor answers with a one-cycle acknowledge pulse, the block works through both levels. It moves the winning lines into service and drives out an 8-bit vector, with a valid strobe, in the following cycle.

Each slice uses fixed priority, where line 0 is the highest. A line can be masked, and it can be either edge- or level-triggered. A request is signalled only if it outranks everything the slice currently has in service. If the acknowledge finds no valid request at a level, the block reports a spurious vector for that level: that level's base with line 7.

An optional cascade nesting mode lets a second slave request reach the processor while an earlier slave interrupt is still in service. It does this by leaving master line 2 out of the master's in-service comparison. Programming of the configuration is outside this block, so masks, trigger modes, vector bases and the mode bit are plain static inputs. A per-slice end-of-service pulse retires in-service lines.

Top module: `irqc_cascade`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `int_out`=0, `vec_valid`=0 and `vec`=0, and all pending and in-service state is cleared.
- R2: An edge-triggered line latches a request on a 0-to-1 change and holds it after the line drops, until it is acknowledged. A level-triggered line (trigger bit 1) has its request follow the line and does not lose it on acknowledge. A master line other than 2 that goes high before clock edge k gives `int_out`=1 after edge k+1, and not before.
- R3: Within a slice, the lowest-numbered request wins among unmasked latched requests (mask bit 1 blocks the line). The slice signals only when that winner is numbered strictly lower than its highest-priority in-service line.
- R4: A signalling slave sets master line 2 on every clock edge. A slave line that goes high before edge k gives `int_out`=1 after edge k+2.
- R5: An `ack` pulse at edge k makes `vec_valid`=1 for exactly the cycle after edge k. `vec` = {base[7:3], line[2:0]} for the chosen level and holds that value until the next acknowledge.
- R6: If the master winner is a line other than 2, the vector uses the master base plus that line. That master line goes into service and, if edge-triggered, its latched request is cleared.
- R7: If the master winner is line 2 and the slave is signalling, both master line 2 and the slave winner go into service. The vector is the slave base plus the slave line.
- R8: If the master is not signalling at acknowledge, the vector is the master base plus 7, and no state changes.
- R9: If the master winner is line 2 but the slave is not signalling, the vector is the slave base plus 7. Master line 2 still goes into service and blocks master lines 3 to 7.
- R10: With `cascade_nest`=1, master in-service line 2 is left out of the master's priority comparison, so a new slave request outranking the slave's own in-service lines reaches `int_out`. The slave's own nesting is unchanged.
- R11: A `done_m`/`done_s` pulse clears the highest-priority (lowest-numbered) in-service line of that slice.
- R12: Bit 2 of `irq_in` has no effect; master line 2 is driven only by the slave.
- R13: An acknowledge and a new request edge in the same cycle: the vector reflects the state before that edge, and the new request is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Request lines; [7:0] master, [15:8] slave lines 0..7 |
| mask_m | input | 8 | Master line mask, 1 = blocked |
| mask_s | input | 8 | Slave line mask, 1 = blocked |
| level_m | input | 8 | Master trigger mode, 1 = level, 0 = edge |
| level_s | input | 8 | Slave trigger mode, 1 = level, 0 = edge |
| base_m | input | 8 | Master vector base; bits [2:0] ignored |
| base_s | input | 8 | Slave vector base; bits [2:0] ignored |
| cascade_nest | input | 1 | Leave master in-service line 2 out of master priority |
| done_m | input | 1 | End-of-service pulse for the master |
| done_s | input | 1 | End-of-service pulse for the slave |
| ack | input | 1 | One-cycle interrupt acknowledge |
| int_out | output | 1 | Registered processor interrupt request |
| vec | output | 8 | Interrupt vector, registered |
| vec_valid | output | 1 | High for the cycle in which a new vector is presented |

## Verification
An acknowledge and a fresh request can land on the same clock edge. The acknowledge has to resolve from the state before that edge, while the new request must still be latched. The bench provokes this by raising a higher-priority master line in the same cycle as an `ack` aimed at a lower one. It then judges the vector against the old winner and checks that `int_out` stays high so the new line can be acknowledged next. The same collision happens inside the block when master line 2 is acknowledged while the slave is still signalling from its pre-edge state. That case is judged by the absence of any spurious re-request after each slave acknowledge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Which level supplies the vector on an acknowledge.
  typedef enum logic [1:0] {
    SRC_MASTER,
    SRC_SLAVE,
    SRC_M_SPUR,
    SRC_S_SPUR
  } vec_src_e;
endpackage

// File: rtl/irqc_prio.sv
// Lowest-index finder: reports whether any bit is set and the index of the
// lowest set bit (highest priority).
module irqc_prio #(
  parameter int N_LINES = 8
) (
  input  logic [N_LINES-1:0]         vec,
  output logic                       hit,
  output logic [$clog2(N_LINES)-1:0] idx
);
  localparam int LW = $clog2(N_LINES);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (vec[i]) begin
        hit = 1'b1;
        idx = LW'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_slice.sv
// One priority slice: request latches, in-service bits, nesting decision.
module irqc_slice #(
  parameter int N_LINES = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_LINES-1:0]         line_in,
  input  logic [N_LINES-1:0]         line_mask,
  input  logic [N_LINES-1:0]         line_lvl,
  input  logic [N_LINES-1:0]         line_force,
  input  logic [N_LINES-1:0]         svc_skip,
  input  logic                       take,
  input  logic [$clog2(N_LINES)-1:0] take_line,
  input  logic                       done,
  output logic                       pend,
  output logic [$clog2(N_LINES)-1:0] win
);
  localparam int LW = $clog2(N_LINES);

  logic [N_LINES-1:0] req_q, svc_q, prev_q;
  logic [N_LINES-1:0] req_d, svc_d, rise, take_vec, done_vec;
  logic               req_hit, cur_hit, top_hit;
  logic [LW-1:0]      req_idx, cur_idx, top_idx;

  // Winner among unmasked latched requests.
  irqc_prio #(.N_LINES(N_LINES)) u_req (
    .vec (req_q & ~line_mask),
    .hit (req_hit),
    .idx (req_idx)
  );

  // Current in-service priority, optionally ignoring some lines.
  irqc_prio #(.N_LINES(N_LINES)) u_cur (
    .vec (svc_q & ~svc_skip),
    .hit (cur_hit),
    .idx (cur_idx)
  );

  // Line retired by an end-of-service pulse.
  irqc_prio #(.N_LINES(N_LINES)) u_top (
    .vec (svc_q),
    .hit (top_hit),
    .idx (top_idx)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign rise[i]     = line_in[i] & ~prev_q[i];
    assign take_vec[i] = take && (take_line == LW'(i));
    assign done_vec[i] = done && top_hit && (top_idx == LW'(i));
    // Level lines mirror the pin; edge lines latch and clear on acknowledge
    // (the clear wins over a same-cycle set).
    assign req_d[i]    = line_lvl[i] ? line_in[i]
                       : ((req_q[i] | rise[i] | line_force[i]) & ~take_vec[i]);
    assign svc_d[i]    = (svc_q[i] & ~done_vec[i]) | take_vec[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      svc_q  <= '0;
      prev_q <= '0;
    end else begin
      req_q  <= req_d;
      svc_q  <= svc_d;
      prev_q <= line_in;
    end
  end

  assign pend = req_hit && (!cur_hit || (req_idx < cur_idx));
  assign win  = req_idx;
endmodule

// File: rtl/irqc_vec.sv
// Two-level acknowledge resolution, vector register and interrupt output.
module irqc_vec
  import irqc_pkg::*;
#(
  parameter int N_LINES  = 8,
  parameter int VEC_W    = 8,
  parameter int CAS_LINE = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ack,
  input  logic                       m_pend,
  input  logic [$clog2(N_LINES)-1:0] m_win,
  input  logic                       s_pend,
  input  logic [$clog2(N_LINES)-1:0] s_win,
  input  logic [VEC_W-1:0]           base_m,
  input  logic [VEC_W-1:0]           base_s,
  output logic                       m_take,
  output logic                       s_take,
  output logic                       int_out,
  output logic [VEC_W-1:0]           vec,
  output logic                       vec_valid
);
  localparam int            LW     = $clog2(N_LINES);
  localparam logic [LW-1:0] SPUR   = LW'(N_LINES - 1);
  localparam logic [LW-1:0] CAS_IX = LW'(CAS_LINE);

  vec_src_e              src;
  logic [LW-1:0]         sel_line;
  logic [VEC_W-LW-1:0]   sel_base;
  logic                  base_unused;

  always_comb begin
    if (!m_pend) begin
      src      = SRC_M_SPUR;
      sel_line = SPUR;
    end else if (m_win == CAS_IX) begin
      if (s_pend) begin
        src      = SRC_SLAVE;
        sel_line = s_win;
      end else begin
        src      = SRC_S_SPUR;
        sel_line = SPUR;
      end
    end else begin
      src      = SRC_MASTER;
      sel_line = m_win;
    end
  end

  assign sel_base    = (src == SRC_MASTER || src == SRC_M_SPUR)
                     ? base_m[VEC_W-1:LW] : base_s[VEC_W-1:LW];
  assign m_take      = ack && m_pend;
  assign s_take      = ack && (src == SRC_SLAVE);
  assign base_unused = ^{base_m[LW-1:0], base_s[LW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      vec       <= '0;
      vec_valid <= 1'b0;
      int_out   <= 1'b0;
    end else begin
      vec_valid <= ack;
      int_out   <= m_pend;
      if (ack) vec <= {sel_base, sel_line};
    end
  end
endmodule

// File: rtl/irqc_cascade.sv
// Top: master and slave slices joined through the cascade line.
module irqc_cascade #(
  parameter int N_LINES  = 8,
  parameter int VEC_W    = 8,
  parameter int CAS_LINE = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2*N_LINES-1:0] irq_in,
  input  logic [N_LINES-1:0]   mask_m,
  input  logic [N_LINES-1:0]   mask_s,
  input  logic [N_LINES-1:0]   level_m,
  input  logic [N_LINES-1:0]   level_s,
  input  logic [VEC_W-1:0]     base_m,
  input  logic [VEC_W-1:0]     base_s,
  input  logic                 cascade_nest,
  input  logic                 done_m,
  input  logic                 done_s,
  input  logic                 ack,
  output logic                 int_out,
  output logic [VEC_W-1:0]     vec,
  output logic                 vec_valid
);
  localparam int LW = $clog2(N_LINES);

  logic [N_LINES-1:0] m_line, m_lvl, m_force, m_skip;
  logic               m_pend, s_pend, m_take, s_take;
  logic [LW-1:0]      m_win, s_win;

  // The cascade line is owned by the slave: external pin dropped, always
  // treated as an edge line set whenever the slave is signalling.
  always_comb begin
    m_line           = irq_in[N_LINES-1:0];
    m_line[CAS_LINE] = 1'b0;
    m_lvl            = level_m;
    m_lvl[CAS_LINE]  = 1'b0;
    m_force          = '0;
    m_force[CAS_LINE] = s_pend;
    m_skip           = '0;
    m_skip[CAS_LINE] = cascade_nest;
  end

  irqc_slice #(.N_LINES(N_LINES)) u_master (
    .clk        (clk),
    .rst        (rst),
    .line_in    (m_line),
    .line_mask  (mask_m),
    .line_lvl   (m_lvl),
    .line_force (m_force),
    .svc_skip   (m_skip),
    .take       (m_take),
    .take_line  (m_win),
    .done       (done_m),
    .pend       (m_pend),
    .win        (m_win)
  );

  irqc_slice #(.N_LINES(N_LINES)) u_slave (
    .clk        (clk),
    .rst        (rst),
    .line_in    (irq_in[2*N_LINES-1:N_LINES]),
    .line_mask  (mask_s),
    .line_lvl   (level_s),
    .line_force ({N_LINES{1'b0}}),
    .svc_skip   ({N_LINES{1'b0}}),
    .take       (s_take),
    .take_line  (s_win),
    .done       (done_s),
    .pend       (s_pend),
    .win        (s_win)
  );

  irqc_vec #(.N_LINES(N_LINES), .VEC_W(VEC_W), .CAS_LINE(CAS_LINE)) u_vec (
    .clk       (clk),
    .rst       (rst),
    .ack       (ack),
    .m_pend    (m_pend),
    .m_win     (m_win),
    .s_pend    (s_pend),
    .s_win     (s_win),
    .base_m    (base_m),
    .base_s    (base_s),
    .m_take    (m_take),
    .s_take    (s_take),
    .int_out   (int_out),
    .vec       (vec),
    .vec_valid (vec_valid)
  );
endmodule

// File: rtl/irqc_cascade_chk.sv
module irqc_cascade_chk #(
  parameter int N_LINES = 8,
  parameter int VEC_W   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ack,
  input logic             m_pend,
  input logic [VEC_W-1:0] base_m,
  input logic [VEC_W-1:0] base_s,
  input logic             int_out,
  input logic [VEC_W-1:0] vec,
  input logic             vec_valid
);
  localparam int LW = $clog2(N_LINES);

  logic base_unused;
  assign base_unused = ^{base_m[LW-1:0], base_s[LW-1:0]};

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!int_out && !vec_valid && (vec == '0)));

  assert_valid_after_ack_R5: assert property (@(posedge clk) disable iff (rst)
    ack |=> vec_valid);

  assert_valid_needs_ack_R5: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(ack));

  assert_vec_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !ack |=> $stable(vec));

  assert_base_choice_R6: assert property (@(posedge clk) disable iff (rst)
    ack |=> ((vec[VEC_W-1:LW] == $past(base_m[VEC_W-1:LW])) ||
             (vec[VEC_W-1:LW] == $past(base_s[VEC_W-1:LW]))));

  assert_master_spurious_R8: assert property (@(posedge clk) disable iff (rst)
    (ack && !m_pend) |=> (vec == {$past(base_m[VEC_W-1:LW]), {LW{1'b1}}}));
endmodule

bind irqc_cascade irqc_cascade_chk #(.N_LINES(N_LINES), .VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ack       (ack),
  .m_pend    (m_pend),
  .base_m    (base_m),
  .base_s    (base_s),
  .int_out   (int_out),
  .vec       (vec),
  .vec_valid (vec_valid)
);

// File: tb/sim_irqc_cascade.sv
module sim_irqc_cascade;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_in = '0;
  logic [7:0]  mask_m = '0, mask_s = '0, level_m = '0, level_s = '0;
  logic [7:0]  base_m = '0, base_s = '0;
  logic        cascade_nest = 1'b0, done_m = 1'b0, done_s = 1'b0, ack = 1'b0;
  logic        int_out, vec_valid;
  logic [7:0]  vec;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  irqc_cascade u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .mask_m(mask_m), .mask_s(mask_s),
    .level_m(level_m), .level_s(level_s), .base_m(base_m), .base_s(base_s),
    .cascade_nest(cascade_nest), .done_m(done_m), .done_s(done_s), .ack(ack),
    .int_out(int_out), .vec(vec), .vec_valid(vec_valid)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; irq_in = '0; ack = 1'b0; done_m = 1'b0; done_s = 1'b0;
    mask_m = '0; mask_s = '0; level_m = '0; level_s = '0; cascade_nest = 1'b0;
    steps(2);
    rst = 1'b0;
  endtask

  task automatic pulse_ack(input string tag, input logic [7:0] exp);
    ack = 1'b1; step(); ack = 1'b0;
    chk({tag, " valid"}, vec_valid, 1);
    chk({tag, " vector"}, vec, exp);
  endtask

  task automatic pulse_done_m();
    done_m = 1'b1; step(); done_m = 1'b0;
  endtask

  task automatic pulse_done_s();
    done_s = 1'b1; step(); done_s = 1'b0;
  endtask

  function automatic logic [2:0] low8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return 3'(i);
    return 3'd7;
  endfunction

  initial begin
    logic [7:0] eff, exp_v, held;
    do_reset();
    chk("R1 int after reset", int_out, 0);
    chk("R1 valid after reset", vec_valid, 0);
    chk("R1 vec after reset", vec, 0);

    // Master sweep: every request pattern, unmasked and masked (R2 R3 R6 R8 R12)
    for (int pass = 0; pass < 2; pass++) begin
      for (int p = 0; p < 256; p++) begin
        do_reset();
        mask_m = (pass == 0) ? 8'h00 : 8'(p * 29 + 7);
        base_m = 8'((p << 3) | 5);
        base_s = 8'hA3;
        irq_in[7:0] = 8'(p);
        step();
        chk("R2 master latency", int_out, 0);
        step();
        eff = 8'(p) & ~mask_m & ~8'h04;
        chk("R3 R12 master int", int_out, (eff != 0) ? 1 : 0);
        exp_v = {base_m[7:3], (eff != 0) ? low8(eff) : 3'd7};
        pulse_ack("R6 R8 master sweep", exp_v);
        held = vec;
        step();
        chk("R5 valid one cycle", vec_valid, 0);
        chk("R5 vec held", vec, held);
      end
    end

    // Slave sweep through the cascade (R4 R7)
    for (int pass = 0; pass < 2; pass++) begin
      for (int q = 0; q < 256; q++) begin
        do_reset();
        mask_s = (pass == 0) ? 8'h00 : 8'(q * 53 + 3);
        base_m = 8'h1D;
        base_s = 8'((q << 3) | 6);
        irq_in[15:8] = 8'(q);
        steps(2);
        chk("R4 slave latency", int_out, 0);
        step();
        eff = 8'(q) & ~mask_s;
        chk("R4 slave int", int_out, (eff != 0) ? 1 : 0);
        exp_v = (eff != 0) ? {base_s[7:3], low8(eff)} : {base_m[7:3], 3'd7};
        pulse_ack("R7 slave sweep", exp_v);
      end
    end

    // Nesting, spurious with service active, end of service (R3 R8 R11)
    do_reset();
    base_m = 8'h40;
    irq_in[5] = 1'b1; steps(2);
    chk("R3 line5 int", int_out, 1);
    pulse_ack("R6 line5", 8'h45);
    irq_in[6] = 1'b1; steps(3);
    chk("R3 lower line blocked", int_out, 0);
    pulse_ack("R8 spurious while in service", 8'h47);
    irq_in[1] = 1'b1; steps(2);
    chk("R3 higher line passes", int_out, 1);
    pulse_ack("R6 line1", 8'h41);
    steps(2);
    chk("R3 line6 still blocked", int_out, 0);
    pulse_done_m(); steps(2);
    chk("R11 first done clears line1 only", int_out, 0);
    pulse_done_m(); step();
    chk("R11 second done releases line6", int_out, 1);
    pulse_ack("R11 line6", 8'h46);

    // Edge retention and level following (R2)
    do_reset();
    base_m = 8'h80;
    irq_in[4] = 1'b1; step(); irq_in[4] = 1'b0; steps(2);
    chk("R2 edge request held", int_out, 1);
    pulse_ack("R2 edge line4", 8'h84);
    pulse_done_m();
    level_m = 8'h08; irq_in[3] = 1'b1; steps(2);
    chk("R2 level request", int_out, 1);
    irq_in[3] = 1'b0; steps(2);
    chk("R2 level drop", int_out, 0);
    pulse_ack("R2 level dropped is spurious", 8'h87);
    irq_in[3] = 1'b1; steps(2);
    pulse_ack("R2 level line3", 8'h83);
    steps(2);
    chk("R2 level in service", int_out, 0);
    pulse_done_m(); step();
    chk("R2 level kept after ack", int_out, 1);

    // Slave spurious, master line 2 in service (R9)
    do_reset();
    base_m = 8'h10; base_s = 8'h68; level_s = 8'h08;
    irq_in[11] = 1'b1; steps(3);
    chk("R4 level slave int", int_out, 1);
    irq_in[11] = 1'b0; step();
    pulse_ack("R9 slave spurious", 8'h6F);
    irq_in[4] = 1'b1; steps(3);
    chk("R9 line2 service blocks line4", int_out, 0);
    pulse_done_m(); step();
    chk("R9 line4 after done", int_out, 1);
    pulse_ack("R9 line4", 8'h14);

    // Cascade nesting mode (R10 R7 R11)
    do_reset();
    base_m = 8'h08; base_s = 8'hC0;
    irq_in[13] = 1'b1; steps(3);
    chk("R7 slave5 int", int_out, 1);
    pulse_ack("R7 slave5", 8'hC5);
    irq_in[11] = 1'b1; steps(4);
    chk("R10 mode off blocks", int_out, 0);
    cascade_nest = 1'b1; steps(2);
    chk("R10 mode on passes", int_out, 1);
    pulse_ack("R10 slave3", 8'hC3);
    irq_in[14] = 1'b1; steps(4);
    chk("R10 slave nesting kept", int_out, 0);
    pulse_done_s(); steps(3);
    chk("R11 slave done clears line3 first", int_out, 0);
    pulse_done_s(); steps(2);
    chk("R11 slave line6 released", int_out, 1);
    pulse_ack("R11 slave6", 8'hC6);

    // Acknowledge colliding with a new request edge (R13)
    do_reset();
    base_m = 8'h30;
    irq_in[5] = 1'b1; steps(2);
    ack = 1'b1; irq_in[1] = 1'b1; step(); ack = 1'b0;
    chk("R13 vector from old state", vec, 8'h35);
    step();
    chk("R13 new request kept", int_out, 1);
    pulse_ack("R13 line1", 8'h31);

    // Reset in mid-operation (R1)
    rst = 1'b1; step();
    chk("R1 int cleared", int_out, 0);
    chk("R1 valid cleared", vec_valid, 0);
    chk("R1 vec cleared", vec, 0);
    rst = 1'b0; irq_in = '0; steps(3);
    chk("R1 state cleared", int_out, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule